// File: doc/BRIEF.md
# Processor Status Flag Unit

This unit holds the six condition and control flags of an 8-bit accumulator CPU: carry, zero, interrupt mask, decimal, overflow and negative. The execution stage asks it to load selected flags from an ALU result. The sequencer asks it to set or clear single flags on command, to reload every flag from a byte pulled off the stack, and to mark an interrupt as entered. The unit has no break flag. Only six flag bits are stored.

The unit always drives the byte that a status push would write to the stack. That byte holds the current flags at their fixed positions. Bit 5 is tied high. Bit 4 tells whether an instruction or an interrupt line caused the push, so the stack memory can take the byte in the push cycle. The interrupt controller uses `irq_masked_o` to hold off maskable requests. Non-maskable requests are never blocked by this output.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_ni` is low, and after reset until a later command changes it, the interrupt mask (I) is 1 and carry, zero, decimal, overflow and negative are 0.
- R2: A pull (`pull_i`=1) loads all six flags on the next edge from `pull_data_i`: C from bit 0, Z from bit 1, I from bit 2, D from bit 3, V from bit 6 and N from bit 7. Bits 5 and 4 of the pulled byte have no effect on any flag.
- R3: `push_byte_o` carries the pre-edge flags at the same bit positions as R2, with bit 5 always 1. Bit 4 is 1 when `push_src_i` codes an instruction (00 plain status push, 01 software break) and 0 when it codes an interrupt (10 maskable, 11 non-maskable).
- R4: A push (`push_i`=1) with source code 01, 10 or 11 sets I to 1 on the next edge. A push with code 00 changes no flag.
- R5: With `upd_n_i`, N takes bit 7 of `result_i`. With `upd_z_i`, Z becomes 1 exactly when `result_i` is zero.
- R6: With `upd_c_i`, C takes `carry_i`. The caller drives `carry_i` as the carry out, or as "no borrow" for a subtraction.
- R7: With `upd_v_i`, V takes `ovf_i`. When `bit_op_i` is also 1, V instead takes bit 6 of `result_i`, which holds the tested operand.
- R8: Explicit set and clear commands take effect on the next edge. Set wins over clear. An explicit command on a flag wins over an ALU update of the same flag. An interrupt-entry push sets I even when I is being cleared in the same cycle.
- R9: A pull wins over every other command, push and update in the same cycle.
- R10: `irq_masked_o` always equals I.
- R11: D changes only through its set or clear commands or a pull. ALU updates never touch D.
- R12: A flag with no pull, command or update aimed at it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| result_i | input | 8 | ALU result, or the tested operand for a bit test |
| carry_i | input | 1 | Carry out, or not-borrow for a subtraction |
| ovf_i | input | 1 | Signed overflow from add or subtract |
| bit_op_i | input | 1 | Bit-test operation: V takes result bit 6 |
| upd_n_i | input | 1 | Load N from the result |
| upd_z_i | input | 1 | Load Z from the result |
| upd_c_i | input | 1 | Load C from carry_i |
| upd_v_i | input | 1 | Load V |
| set_c_i | input | 1 | Set carry |
| clr_c_i | input | 1 | Clear carry |
| set_i_i | input | 1 | Set interrupt mask |
| clr_i_i | input | 1 | Clear interrupt mask |
| set_d_i | input | 1 | Set decimal |
| clr_d_i | input | 1 | Clear decimal |
| clr_v_i | input | 1 | Clear overflow |
| push_i | input | 1 | Status push strobe |
| push_src_i | input | 2 | Push source: 00 status push, 01 break, 10 IRQ, 11 NMI |
| pull_i | input | 1 | Status pull strobe |
| pull_data_i | input | 8 | Byte pulled from the stack |
| c_o | output | 1 | Carry flag |
| z_o | output | 1 | Zero flag |
| i_o | output | 1 | Interrupt mask flag |
| d_o | output | 1 | Decimal flag |
| v_o | output | 1 | Overflow flag |
| n_o | output | 1 | Negative flag |
| irq_masked_o | output | 1 | Maskable interrupts blocked |
| push_byte_o | output | 8 | Byte to write on a status push |

## Verification
The assertions assume that every control input is driven to a known 0 or 1 on each clock edge while the unit is out of reset. They also assume that `push_src_i` and `pull_data_i` are valid whenever their strobe is high. The bench changes inputs only on the falling edge. It returns every strobe and command to 0 after each step, so only the stimulus of the step under test meets an edge. The mixed cases put several conflicting commands into a single cycle on purpose, to exercise each priority rule.

// File: rtl/status_pkg.sv
package status_pkg;
  localparam int STAT_W  = 8;
  localparam int POS_C   = 0;
  localparam int POS_Z   = 1;
  localparam int POS_I   = 2;
  localparam int POS_D   = 3;
  localparam int POS_SRC = 4;
  localparam int POS_ONE = 5;
  localparam int POS_V   = 6;
  localparam int POS_N   = 7;

  typedef enum logic [1:0] {
    SRC_PHP = 2'b00,
    SRC_BRK = 2'b01,
    SRC_IRQ = 2'b10,
    SRC_NMI = 2'b11
  } push_src_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/status_alu_eval.sv
module status_alu_eval #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              bit_op_i,
  output logic              alu_n_o,
  output logic              alu_z_o,
  output logic              alu_c_o,
  output logic              alu_v_o
);
  localparam int MSB = DATA_W - 1;
  localparam int SUB = DATA_W - 2;

  always_comb begin
    alu_n_o = result_i[MSB];
    alu_z_o = ~|result_i;
    alu_c_o = carry_i;
    // bit test copies operand bit 6 into V
    alu_v_o = bit_op_i ? result_i[SUB] : ovf_i;
  end
endmodule

// File: rtl/status_flag_cell.sv
module status_flag_cell #(
  parameter bit RST_VAL = 1'b0,
  parameter bit HAS_SET = 1'b1,
  parameter bit HAS_CLR = 1'b1,
  parameter bit HAS_UPD = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pull_i,
  input  logic pull_bit_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic upd_val_i,
  output logic q_o
);
  logic q_d, q_q;

  // priority: pull > set > clear > update
  always_comb begin
    q_d = q_q;
    if (HAS_UPD && upd_i) q_d = upd_val_i;
    if (HAS_CLR && clr_i) q_d = 1'b0;
    if (HAS_SET && set_i) q_d = 1'b1;
    if (pull_i)           q_d = pull_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_PULL_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i |=> q_o == $past(pull_bit_i)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pull_i && !(HAS_SET && set_i) && !(HAS_CLR && clr_i) && !(HAS_UPD && upd_i))
      |=> $stable(q_o)); // R12

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_SET && set_i && !pull_i) |=> q_o); // R8
endmodule

// File: rtl/status_push_fmt.sv
module status_push_fmt
  import status_pkg::*;
(
  input  flags_t            flags_i,
  input  push_src_e         src_i,
  output logic [STAT_W-1:0] byte_o
);
  logic from_instr;

  assign from_instr = (src_i == SRC_PHP) || (src_i == SRC_BRK);

  always_comb begin
    byte_o          = '0;
    byte_o[POS_C]   = flags_i.c;
    byte_o[POS_Z]   = flags_i.z;
    byte_o[POS_I]   = flags_i.i;
    byte_o[POS_D]   = flags_i.d;
    byte_o[POS_SRC] = from_instr;
    byte_o[POS_ONE] = 1'b1;
    byte_o[POS_V]   = flags_i.v;
    byte_o[POS_N]   = flags_i.n;
  end
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] result_i,
  input  logic              carry_i,
  input  logic              ovf_i,
  input  logic              bit_op_i,
  input  logic              upd_n_i,
  input  logic              upd_z_i,
  input  logic              upd_c_i,
  input  logic              upd_v_i,
  input  logic              set_c_i,
  input  logic              clr_c_i,
  input  logic              set_i_i,
  input  logic              clr_i_i,
  input  logic              set_d_i,
  input  logic              clr_d_i,
  input  logic              clr_v_i,
  input  logic              push_i,
  input  logic [1:0]        push_src_i,
  input  logic              pull_i,
  input  logic [STAT_W-1:0] pull_data_i,
  output logic              c_o,
  output logic              z_o,
  output logic              i_o,
  output logic              d_o,
  output logic              v_o,
  output logic              n_o,
  output logic              irq_masked_o,
  output logic [STAT_W-1:0] push_byte_o
);
  localparam int NFLAGS = 6;

  // per-flag bank description, index order n,v,d,i,z,c (MSB first)
  localparam bit [NFLAGS-1:0] RST_VEC = 6'b000100;
  localparam bit [NFLAGS-1:0] SET_VEC = 6'b001101;
  localparam bit [NFLAGS-1:0] CLR_VEC = 6'b011101;
  localparam bit [NFLAGS-1:0] UPD_VEC = 6'b110011;
  localparam int              POS_TAB [NFLAGS] = '{POS_C, POS_Z, POS_I, POS_D, POS_V, POS_N};

  push_src_e           src;
  logic                alu_n, alu_z, alu_c, alu_v;
  logic                intr_entry;
  logic [NFLAGS-1:0]   set_vec, clr_vec, upd_vec, upd_val, pull_vec, q_vec;
  flags_t              flags;

  assign src        = push_src_e'(push_src_i);
  assign intr_entry = push_i && (src != SRC_PHP);

  status_alu_eval #(.DATA_W(STAT_W)) u_alu_eval (
    .result_i (result_i),
    .carry_i  (carry_i),
    .ovf_i    (ovf_i),
    .bit_op_i (bit_op_i),
    .alu_n_o  (alu_n),
    .alu_z_o  (alu_z),
    .alu_c_o  (alu_c),
    .alu_v_o  (alu_v)
  );

  always_comb begin
    set_vec = {1'b0,  1'b0,    set_d_i, set_i_i | intr_entry, 1'b0,    set_c_i};
    clr_vec = {1'b0,  clr_v_i, clr_d_i, clr_i_i,              1'b0,    clr_c_i};
    upd_vec = {upd_n_i, upd_v_i, 1'b0,  1'b0,                 upd_z_i, upd_c_i};
    upd_val = {alu_n, alu_v,   1'b0,    1'b0,                 alu_z,   alu_c};
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    assign pull_vec[g] = pull_data_i[POS_TAB[g]];
    status_flag_cell #(
      .RST_VAL (RST_VEC[g]),
      .HAS_SET (SET_VEC[g]),
      .HAS_CLR (CLR_VEC[g]),
      .HAS_UPD (UPD_VEC[g])
    ) u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pull_i     (pull_i),
      .pull_bit_i (pull_vec[g]),
      .set_i      (set_vec[g]),
      .clr_i      (clr_vec[g]),
      .upd_i      (upd_vec[g]),
      .upd_val_i  (upd_val[g]),
      .q_o        (q_vec[g])
    );
  end

  assign flags = flags_t'(q_vec);

  status_push_fmt u_push_fmt (
    .flags_i (flags),
    .src_i   (src),
    .byte_o  (push_byte_o)
  );

  assign c_o          = flags.c;
  assign z_o          = flags.z;
  assign i_o          = flags.i;
  assign d_o          = flags.d;
  assign v_o          = flags.v;
  assign n_o          = flags.n;
  assign irq_masked_o = flags.i;

  AST_INTR_SETS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && push_src_i != 2'b00 && !pull_i) |=> i_o); // R4

  AST_PLAIN_PUSH_KEEPS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && push_src_i == 2'b00 && !pull_i && !set_i_i && !clr_i_i) |=> $stable(i_o)); // R4

  AST_ZERO_DETECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_z_i && !pull_i) |=> z_o == ($past(result_i) == '0)); // R5

  AST_BIT_TEST_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_v_i && bit_op_i && !clr_v_i && !pull_i) |=> v_o == $past(result_i[6])); // R7

  AST_DECIMAL_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pull_i && !set_d_i && !clr_d_i) |=> $stable(d_o)); // R11

  AST_MASK_FALLS_ONLY_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(i_o) |-> ($past(pull_i) || $past(clr_i_i))); // R8
endmodule

// File: tb/cpu_status_reg_tb_top.sv
`timescale 1ns/1ps
module cpu_status_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] result = '0;
  logic       carry = 0, ovf = 0, bit_op = 0;
  logic       upd_n = 0, upd_z = 0, upd_c = 0, upd_v = 0;
  logic       set_c = 0, clr_c = 0, set_i = 0, clr_i = 0, set_d = 0, clr_d = 0, clr_v = 0;
  logic       push = 0, pull = 0;
  logic [1:0] src = '0;
  logic [7:0] pull_data = '0;
  logic       c_o, z_o, i_o, d_o, v_o, n_o, irq_masked_o;
  logic [7:0] push_byte_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model = 8'h04;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cpu_status_reg dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .result_i(result), .carry_i(carry), .ovf_i(ovf),
    .bit_op_i(bit_op), .upd_n_i(upd_n), .upd_z_i(upd_z), .upd_c_i(upd_c), .upd_v_i(upd_v),
    .set_c_i(set_c), .clr_c_i(clr_c), .set_i_i(set_i), .clr_i_i(clr_i), .set_d_i(set_d),
    .clr_d_i(clr_d), .clr_v_i(clr_v), .push_i(push), .push_src_i(src), .pull_i(pull),
    .pull_data_i(pull_data), .c_o(c_o), .z_o(z_o), .i_o(i_o), .d_o(d_o), .v_o(v_o),
    .n_o(n_o), .irq_masked_o(irq_masked_o), .push_byte_o(push_byte_o)
  );

  function automatic logic [7:0] observed();
    return {n_o, v_o, 2'b00, d_o, i_o, z_o, c_o};
  endfunction

  function automatic logic [7:0] model_next(logic [7:0] f);
    logic [7:0] nx = f;
    if (upd_n) nx[7] = result[7];
    if (upd_z) nx[1] = (result == 8'h00);
    if (upd_c) nx[0] = carry;
    if (upd_v) nx[6] = bit_op ? result[6] : ovf;
    if (clr_c) nx[0] = 1'b0;
    if (set_c) nx[0] = 1'b1;
    if (clr_v) nx[6] = 1'b0;
    if (clr_d) nx[3] = 1'b0;
    if (set_d) nx[3] = 1'b1;
    if (clr_i) nx[2] = 1'b0;
    if (set_i || (push && src != 2'b00)) nx[2] = 1'b1;
    if (pull) nx = pull_data & 8'hCF;
    return nx;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {carry, ovf, bit_op, upd_n, upd_z, upd_c, upd_v} = '0;
    {set_c, clr_c, set_i, clr_i, set_d, clr_d, clr_v, push, pull} = '0;
    src = 2'b00; result = 8'h00; pull_data = 8'h00;
  endtask

  // driver: inputs already set at the falling edge; check push byte, queue expected flags
  task automatic step(string tag);
    #1;
    check({tag, " R3 push byte"}, push_byte_o,
          {model[7], model[6], 1'b1, (src == 2'b00 || src == 2'b01), model[3:0]});
    model = model_next(model);
    exp_q.push_back(model);
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
    clear_inputs();
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, observed(), e);
        check({t, " R10 irq_masked"}, {7'b0, irq_masked_o}, {7'b0, e[2]});
      end
    end
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset flags", observed(), 8'h04);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 after release", observed(), 8'h04);
    check("R10 mask after reset", {7'b0, irq_masked_o}, 8'h01);

    pull = 1; pull_data = 8'hFF;                       step("R2 pull all ones");
    src = 2'b10;                                       step("R3 irq push byte, R12 idle hold");
    pull = 1; pull_data = 8'h30;                       step("R2 pull ignores bits 5,4");
    src = 2'b11;                                       step("R3 nmi push byte");
    pull = 1; pull_data = 8'hC9;                       step("R2 pull mixed");
    pull = 1; pull_data = 8'h06; src = 2'b01;          step("R2 pull low bits");

    result = 8'h00; upd_n = 1; upd_z = 1;              step("R5 zero result");
    result = 8'h80; upd_n = 1; upd_z = 1;              step("R5 negative result");
    result = 8'h01; upd_z = 1;                         step("R5 z only");
    carry = 1; upd_c = 1;                              step("R6 carry set");
    carry = 0; upd_c = 1; result = 8'hFF;              step("R6 carry clear");
    ovf = 1; upd_v = 1;                                step("R7 overflow");
    ovf = 1; upd_v = 1; bit_op = 1; result = 8'hBF;    step("R7 bit test bit6 low");
    ovf = 0; upd_v = 1; bit_op = 1; result = 8'h40;    step("R7 bit test bit6 high");

    set_c = 1; upd_c = 1; carry = 0;                   step("R8 set beats update");
    clr_c = 1; upd_c = 1; carry = 1;                   step("R8 clear beats update");
    clr_v = 1; upd_v = 1; ovf = 1;                     step("R8 clr_v beats update");
    set_d = 1; clr_d = 1;                              step("R8 set beats clear");
    upd_n = 1; upd_z = 1; upd_c = 1; upd_v = 1; result = 8'h00; carry = 1;
                                                       step("R11 alu leaves D");
    clr_d = 1;                                         step("R8 clear decimal");
    clr_i = 1;                                         step("R8 clear mask");
    push = 1; src = 2'b00;                             step("R4 plain push no change");
    push = 1; src = 2'b01;                             step("R4 break sets mask");
    clr_i = 1;                                         step("R8 clear mask again");
    push = 1; src = 2'b10; clr_i = 1;                  step("R4 R8 irq push beats clear");
    clr_i = 1;                                         step("R8 clear mask third");
    push = 1; src = 2'b11;                             step("R4 nmi sets mask");
    set_i = 1; set_c = 1; set_d = 1; upd_n = 1; result = 8'h80;
    pull = 1; pull_data = 8'h32;                       step("R9 pull beats all");
    push = 1; src = 2'b01; pull = 1; pull_data = 8'h00; step("R9 pull beats push");
    result = 8'hAA; carry = 1; ovf = 1;                step("R12 no enables hold");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule